// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI configuration header. It captures error and abort events reported by the bus interface into sticky flags. Software clears each flag by writing a 1 to its position. The remaining positions are fixed fields that advertise the device's capabilities and its device-select timing. The read value after reset is 0x0210.

The configuration port has single-cycle read and write strobes, a 16-bit write word and two byte enables. It never stalls: a strobe is always accepted in the cycle it is asserted, so there is no back-pressure. Read data is driven combinationally in the cycle of the read strobe and is zero in every other cycle.

The event inputs are one-cycle pulses. The SERR enable, the parity-error-response enable and the bus-master flag are level inputs, sampled in the same cycle as the pulse they qualify.

Top module: `pci_cfg_status_reg`

## Requirements
- R1: After reset the register reads 0x0210.
- R2: A pulse on `ev_parity_det` sets bit 15.
- R3: Bit 14 sets on a pulse on `ev_serr_sig` only while `cmd_serr_en` is 1.
- R4: A pulse on `ev_mabort_rcv` sets bit 13, and a pulse on `ev_tabort_rcv` sets bit 12.
- R5: A pulse on `ev_tabort_sig` sets bit 11.
- R6: Bit 8 sets on a pulse on `ev_perr_seen` only when `is_master` and `cmd_perr_resp` are both 1 in that cycle.
- R7: A write with `cfg_be[1]` set clears each of bits 15, 14, 13, 12, 11 and 8 whose write-data bit is 1. A 0 in those positions leaves the bit unchanged.
- R8: A write with only `cfg_be[0]` set changes no bit. Write data in bits 10:9 and 7:0 is ignored.
- R9: If a sticky bit's event and its write-1 clear arrive in the same cycle, the bit ends at 1.
- R10: Bits 10:9 always read 01, bit 4 always reads 1, and bits 7:5 and 3:0 always read 0.
- R11: `cfg_rdata` shows the current value in the cycle `cfg_rd_en` is 1, including the value from before a write in that same cycle. It is 0 when `cfg_rd_en` is 0. A read changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables; bit 1 covers bits 15:8 |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, combinational |
| ev_parity_det | input | 1 | Address or data parity error detected |
| ev_serr_sig | input | 1 | System error signalled by this device |
| ev_mabort_rcv | input | 1 | Own master cycle ended in master abort |
| ev_tabort_rcv | input | 1 | Own master cycle ended in target abort |
| ev_tabort_sig | input | 1 | This device ended a transaction with target abort |
| ev_perr_seen | input | 1 | PERR observed on the bus |
| cmd_serr_en | input | 1 | SERR enable from the command register |
| cmd_perr_resp | input | 1 | Parity-error-response enable from the command register |
| is_master | input | 1 | This device owns the current data phase as master |

## Verification
Every internal flag appears on the next read, so a lost or stuck sticky bit shows up as a wrong bit in `cfg_rdata` on the first read after the cycle that should have changed it. A clear that is decoded from the wrong byte lane shows on the read that follows that write. A set that fails to win over a clear shows the same way. A corrupted fixed field is wrong on every read, including the first read after reset.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int REG_W      = 16;
  localparam int LANE_W     = 8;
  localparam int NUM_LANES  = REG_W / LANE_W;
  localparam int NUM_STICKY = 6;

  // Fixed capability and timing fields: DEVSEL medium (bits 10:9 = 01), capability list (bit 4)
  localparam logic [REG_W-1:0] FIXED_VAL = 16'h0210;

  // Sticky flag order: 0 parity, 1 serr, 2 master abort, 3 target abort received,
  // 4 target abort signalled, 5 data parity
  function automatic int sticky_pos(input int idx);
    case (idx)
      0:       return 15;
      1:       return 14;
      2:       return 13;
      3:       return 12;
      4:       return 11;
      default: return 8;
    endcase
  endfunction

  typedef struct packed {
    logic parity_det;
    logic serr_sig;
    logic mabort_rcv;
    logic tabort_rcv;
    logic tabort_sig;
    logic perr_seen;
  } pcs_events_t;
endpackage

// File: rtl/pcs_event_qual.sv
module pcs_event_qual
  import pcs_pkg::*;
#(
  parameter int N = NUM_STICKY
) (
  input  pcs_events_t   ev,
  input  logic          serr_en,
  input  logic          perr_resp,
  input  logic          master,
  output logic [N-1:0]  set_vec
);
  always_comb begin
    set_vec    = '0;
    set_vec[0] = ev.parity_det;
    set_vec[1] = ev.serr_sig & serr_en;
    set_vec[2] = ev.mabort_rcv;
    set_vec[3] = ev.tabort_rcv;
    set_vec[4] = ev.tabort_sig;
    set_vec[5] = ev.perr_seen & master & perr_resp;
  end
endmodule

// File: rtl/pcs_clear_decode.sv
module pcs_clear_decode
  import pcs_pkg::*;
#(
  parameter int N = NUM_STICKY
) (
  input  logic                 wr_en,
  input  logic [NUM_LANES-1:0] be,
  input  logic [REG_W-1:0]     wdata,
  output logic [N-1:0]         clr_vec
);
  for (genvar i = 0; i < N; i++) begin : g_clr
    localparam int POS  = sticky_pos(i);
    localparam int LANE = POS / LANE_W;
    assign clr_vec[i] = wr_en & be[LANE] & wdata[POS];
  end
endmodule

// File: rtl/pcs_sticky_bit.sv
module pcs_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/pcs_readback.sv
module pcs_readback
  import pcs_pkg::*;
#(
  parameter int N = NUM_STICKY
) (
  input  logic [N-1:0]     sticky,
  output logic [REG_W-1:0] value
);
  always_comb begin
    value = FIXED_VAL;
    for (int i = 0; i < N; i++) value[sticky_pos(i)] = sticky[i];
  end
endmodule

// File: rtl/pci_cfg_status_reg.sv
module pci_cfg_status_reg
  import pcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_rd_en,
  input  logic                 cfg_wr_en,
  input  logic [NUM_LANES-1:0] cfg_be,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [REG_W-1:0]     cfg_rdata,
  input  logic                 ev_parity_det,
  input  logic                 ev_serr_sig,
  input  logic                 ev_mabort_rcv,
  input  logic                 ev_tabort_rcv,
  input  logic                 ev_tabort_sig,
  input  logic                 ev_perr_seen,
  input  logic                 cmd_serr_en,
  input  logic                 cmd_perr_resp,
  input  logic                 is_master
);
  pcs_events_t            ev;
  logic [NUM_STICKY-1:0]  set_vec;
  logic [NUM_STICKY-1:0]  clr_vec;
  logic [NUM_STICKY-1:0]  sticky_q;
  logic [REG_W-1:0]       stat_q;

  assign ev = '{parity_det: ev_parity_det, serr_sig: ev_serr_sig,
                mabort_rcv: ev_mabort_rcv, tabort_rcv: ev_tabort_rcv,
                tabort_sig: ev_tabort_sig, perr_seen: ev_perr_seen};

  pcs_event_qual #(.N(NUM_STICKY)) i_qual (
    .ev(ev), .serr_en(cmd_serr_en), .perr_resp(cmd_perr_resp),
    .master(is_master), .set_vec(set_vec)
  );

  pcs_clear_decode #(.N(NUM_STICKY)) i_clr (
    .wr_en(cfg_wr_en), .be(cfg_be), .wdata(cfg_wdata), .clr_vec(clr_vec)
  );

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_bit
    pcs_sticky_bit i_bit (
      .clk(clk), .rst_n(rst_n), .set(set_vec[i]), .clr(clr_vec[i]), .q(sticky_q[i])
    );
  end

  pcs_readback #(.N(NUM_STICKY)) i_rb (.sticky(sticky_q), .value(stat_q));

  assign cfg_rdata = cfg_rd_en ? stat_q : '0;
endmodule

// File: rtl/pcs_status_chk.sv
module pcs_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_rd_en,
  input logic        cfg_wr_en,
  input logic [1:0]  cfg_be,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic        ev_parity_det,
  input logic        ev_serr_sig,
  input logic        ev_mabort_rcv,
  input logic        ev_perr_seen,
  input logic        cmd_serr_en,
  input logic        cmd_perr_resp,
  input logic        is_master,
  input logic [15:0] stat_q
);
  // R10
  fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |-> (cfg_rdata[10:9] == 2'b01 && cfg_rdata[7:0] == 8'h10));

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_en |-> cfg_rdata == 16'h0000);

  // R2
  parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_parity_det |=> stat_q[15]);

  // R3
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[14] && !(ev_serr_sig && cmd_serr_en)) |=> !stat_q[14]);

  // R6
  dpar_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perr_seen && is_master && cmd_perr_resp) |=> stat_q[8]);

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_be[1] && cfg_wdata[15] && !ev_parity_det) |=> !stat_q[15]);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mabort_rcv && cfg_wr_en && cfg_be[1] && cfg_wdata[13]) |=> stat_q[13]);

  // R8
  hold_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[13] && !(cfg_wr_en && cfg_be[1] && cfg_wdata[13])) |=> stat_q[13]);
endmodule

bind pci_cfg_status_reg pcs_status_chk i_status_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .ev_parity_det(ev_parity_det), .ev_serr_sig(ev_serr_sig),
  .ev_mabort_rcv(ev_mabort_rcv), .ev_perr_seen(ev_perr_seen),
  .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
  .is_master(is_master), .stat_q(stat_q)
);

// File: tb/test_pci_cfg_status_reg.sv
module test_pci_cfg_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rd_en = 1'b0, cfg_wr_en = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [5:0]  ev = '0;  // [5] parity [4] serr [3] mabort [2] tabort rcv [1] tabort sig [0] perr
  logic        cmd_serr_en = 1'b0, cmd_perr_resp = 1'b0, is_master = 1'b0;
  logic        mon_arm = 1'b0;

  int unsigned vectors = 0, miscompares = 0;
  logic [15:0] model = 16'h0210;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #4 clk = ~clk;

  pci_cfg_status_reg i_pci_cfg_status_reg (
    .clk(clk), .rst_n(rst_n), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_parity_det(ev[5]), .ev_serr_sig(ev[4]), .ev_mabort_rcv(ev[3]),
    .ev_tabort_rcv(ev[2]), .ev_tabort_sig(ev[1]), .ev_perr_seen(ev[0]),
    .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp), .is_master(is_master)
  );

  // Driver: applies one cycle of stimulus, pushes the expected read word, advances the model
  task automatic cyc(input logic [5:0] e, input logic wr, input logic [1:0] be,
                     input logic [15:0] wd, input logic rd, input logic chk, input string tag);
    logic [15:0] nxt;
    logic [5:0]  s;
    @(posedge clk); #1;
    ev = e; cfg_wr_en = wr; cfg_be = be; cfg_wdata = wd; cfg_rd_en = rd; mon_arm = chk;
    if (chk) begin
      exp_q.push_back(rd ? model : 16'h0000);
      tag_q.push_back(tag);
    end
    s = {e[5], e[4] & cmd_serr_en, e[3], e[2], e[1], e[0] & is_master & cmd_perr_resp};
    nxt = model;
    foreach (s[k]) begin
      int p;
      p = (k == 0) ? 8 : 10 + k;
      if (s[k]) nxt[p] = 1'b1;
      else if (wr && be[1] && wd[p]) nxt[p] = 1'b0;
    end
    model = nxt;
  endtask

  task automatic rd(input string tag);
    cyc(6'b0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b1, tag);
  endtask

  // Monitor: compares the read data against the scoreboard between edges
  always @(negedge clk) begin
    if (mon_arm && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (cfg_rdata !== e) begin
        miscompares++;
        $display("FAIL %s: rdata=%h expected=%h", t, cfg_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R1 reset value");
    cyc(6'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b1, "R11 idle read zero");
    cyc(6'b100000, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R2 parity set");
    rd("R11 read has no side effect");
    cyc(6'b010000, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R3 serr gated off");
    cmd_serr_en = 1'b1;
    cyc(6'b010000, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R3 serr enabled");
    cyc(6'b001000, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R4 master abort");
    cyc(6'b000100, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R4 target abort received");
    cyc(6'b000010, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R5 target abort signalled");
    cmd_perr_resp = 1'b1; is_master = 1'b0;
    cyc(6'b000001, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R6 not master");
    cmd_perr_resp = 1'b0; is_master = 1'b1;
    cyc(6'b000001, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R6 response disabled");
    cmd_perr_resp = 1'b1;
    cyc(6'b000001, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R6 all conditions");
    cyc(6'b0, 1'b1, 2'b01, 16'hFFFF, 1'b0, 1'b0, "");
    rd("R8 low lane write ignored");
    cyc(6'b0, 1'b1, 2'b10, 16'h06FF, 1'b0, 1'b0, "");
    rd("R8 read-only and zero bits ignored");
    cyc(6'b0, 1'b1, 2'b10, 16'h8000, 1'b0, 1'b0, "");
    rd("R7 clear bit 15");
    cyc(6'b0, 1'b1, 2'b11, 16'h4800, 1'b0, 1'b0, "");
    rd("R7 clear bits 14 and 11");
    cyc(6'b001000, 1'b1, 2'b10, 16'h2000, 1'b1, 1'b1, "R11 read during write shows old value");
    rd("R9 set beats clear bit 13");
    cyc(6'b0, 1'b1, 2'b10, 16'h3100, 1'b0, 1'b0, "");
    rd("R7 clear remaining");
    cyc(6'b100000, 1'b1, 2'b10, 16'hFFFF, 1'b0, 1'b0, "");
    rd("R9 set beats clear bit 15");
    cmd_serr_en = 1'b0;
    cyc(6'b111111, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    rd("R10 fields with all events");
    cyc(6'b0, 1'b1, 2'b10, 16'hFFFF, 1'b0, 1'b0, "");
    rd("R7 clear all");
    rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1; model = 16'h0210;
    rd("R1 value after second reset");
    cyc(6'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, "");
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule